// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block builds the outgoing byte stream of one line port from 53-byte ATM cells. A cell buffer upstream shows whether a whole cell is ready and offers its current byte. The line side requests bytes one at a time. For every request the block emits one byte, one cycle later. At each cell boundary it chooses the source for the next cell. If the buffer has a cell ready, that cell is forwarded. If not, a rate-decoupling filler cell is generated.

The fifth byte of each cell carries the header check. The block computes it as a CRC-8 over the four leading header bytes, XORs in a programmable coset, and inserts the result. For test, a one-shot request flips one bit of the next inserted check byte. The 48 payload bytes may be scrambled with a self-synchronising scrambler whose state carries over from cell to cell. A saturating counter records the assigned cells sent without an injected check error.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: While reset is held and after it is released, `out_vld`, `out_soc` and `cell_rd` are low and `good_cells` reads 0 until the first request.
- R2: Each cycle with `out_req` high yields `out_vld` high with a byte on the next cycle. `out_soc` is high only with byte 0 of each 53-byte cell.
- R3: If `cell_rdy` is high when byte 0 is requested, the whole cell comes from `cell_byte`. `cell_rd` is high in the same cycle as every request of that cell, and every byte other than byte 4 is forwarded unchanged when scrambling is off.
- R4: When insertion is enabled, byte 4 is replaced by CRC-8 (generator x^8+x^2+x+1, initial value 0, MSB first) over bytes 0 to 3, XOR `cfg_coset`. With `cfg_hec_en` low, byte 4 of a user cell passes unchanged.
- R5: A one-cycle pulse on `hec_err_req` inverts bit 0 of the next inserted check byte, in exactly one cell. A user cell sent with insertion disabled does not consume the request.
- R6: If no cell is ready at byte 0, a filler cell is sent and `cell_rd` stays low. Its header is 00 00 00 01 when `cfg_fill_unassigned` is 0 (idle) and 00 00 00 00 when it is 1. Its check byte is always inserted, and all 48 payload bytes equal `cfg_fill_byte`.
- R7: With `cfg_scr_en` high, each payload bit (MSB first) is XORed with the scrambled output bit sent 43 payload bits earlier, and that history starts at zero after reset. Header bytes, and payload bytes sent with scrambling off, neither use nor advance the history.
- R8: `good_cells` increases by one at the edge that emits the last byte of a user cell whose check byte was not corrupted. Filler cells and corrupted cells leave it unchanged, and it holds at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cell_rdy | input | 1 | A complete cell is waiting in the buffer |
| cell_byte | input | 8 | Current byte offered by the buffer |
| cell_rd | output | 1 | Buffer byte consumed this cycle |
| out_req | input | 1 | Line side asks for one byte |
| out_vld | output | 1 | `out_byte` holds a requested byte |
| out_soc | output | 1 | Byte is the first of a cell |
| out_byte | output | 8 | Outgoing byte |
| cfg_hec_en | input | 1 | Insert computed check byte in user cells |
| cfg_coset | input | 8 | Value XORed onto the computed check |
| cfg_scr_en | input | 1 | Scramble payload bytes |
| cfg_fill_unassigned | input | 1 | Filler is unassigned (1) or idle (0) |
| cfg_fill_byte | input | 8 | Payload byte of filler cells |
| hec_err_req | input | 1 | Corrupt the next inserted check byte |
| good_cells | output | CNT_W | Saturating count of error-free user cells |

## Verification
`cell_rd` is combinational, so it is due in the cycle of the request. It is sampled a short delay after inputs change on the falling edge. `out_byte`, `out_vld` and `out_soc` are due one edge after the request, and `good_cells` moves on the same edge that emits a cell's last byte. The bench drives one request on a falling edge and reads the outputs on the next falling edge, before it drives anything else. Scrambled payload is predicted from a record of every scrambled bit already sent. The check value uses a bit-serial division written separately in the bench, and the filler headers are checked against the fixed values 0x52 and 0x55 for coset 0x55.

// File: rtl/atm_tx_pkg.sv
// Shared constants and byte-wide helper functions for the transmit cell path.
// Assumes MSB-first bit order on the line for both the check and the scrambler.
package atm_tx_pkg;
    localparam int CELL_BYTES = 53;
    localparam int HDR_BYTES  = 4;            // bytes covered by the check
    localparam int HEC_IDX    = HDR_BYTES;    // position of the check byte
    localparam int SCR_W      = 43;           // scrambler history length
    localparam logic [7:0] CRC_POLY = 8'h07;  // x^8+x^2+x+1 without x^8

    typedef struct packed {
        logic [SCR_W-1:0] st;
        logic [7:0]       q;
    } scr_res_t;

    // One byte of CRC-8 update, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
        logic [7:0] c;
        c = crc ^ d;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

    // One byte of x^43+1 self-synchronising scrambling, MSB first.
    function automatic scr_res_t scr_byte(input logic [SCR_W-1:0] st_in, input logic [7:0] d);
        scr_res_t r;
        r.st = st_in;
        r.q  = '0;
        for (int i = 7; i >= 0; i--) begin
            r.q[i] = d[i] ^ r.st[SCR_W-1];
            r.st   = {r.st[SCR_W-2:0], r.q[i]};
        end
        return r;
    endfunction
endpackage

// File: rtl/atm_tx_hec.sv
// Accumulates the CRC-8 over the header bytes of the current cell.
// Assumes the caller asserts step for each header byte in order, first on byte 0.
module atm_tx_hec
    import atm_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       first,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    // Restart on byte 0, fold in each following header byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc <= '0;
        else if (step) crc <= crc8_step(first ? 8'h00 : crc, din);
    end
endmodule

// File: rtl/atm_tx_scrambler.sv
// Payload scrambler with polynomial x^43+1; state advances only when en is high.
// Assumes the caller raises en for payload bytes only, and only when scrambling is on.
module atm_tx_scrambler
    import atm_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [SCR_W-1:0] st_q;
    scr_res_t         res;

    // Combinational scrambled byte for the current state.
    always_comb begin
        res  = scr_byte(st_q, din);
        dout = res.q;
    end

    // Advance history on scrambled payload bytes only.
    always_ff @(posedge clk) begin
        if (!rst_n)  st_q <= '0;
        else if (en) st_q <= res.st;
    end

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q));
endmodule

// File: rtl/atm_tx_good_cnt.sv
// Saturating counter of error-free assigned cells.
// Assumes inc is a single-cycle pulse per qualifying cell.
module atm_tx_good_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count up, stop at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (inc && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
    end

    assert_cnt_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt >= $past(cnt));
    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt - $past(cnt)) <= CNT_W'(1));
endmodule

// File: rtl/atm_tx_cell_proc.sv
// Transmit cell processor: selects a user or filler cell at each boundary, inserts
// the header check with coset and optional one-shot error, scrambles payload and
// counts good user cells. Assumes a ready cell stays ready until its last byte,
// and configuration changes only between cells.
module atm_tx_cell_proc
    import atm_tx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_rdy,
    input  logic [7:0]       cell_byte,
    output logic             cell_rd,
    input  logic             out_req,
    output logic             out_vld,
    output logic             out_soc,
    output logic [7:0]       out_byte,
    input  logic             cfg_hec_en,
    input  logic [7:0]       cfg_coset,
    input  logic             cfg_scr_en,
    input  logic             cfg_fill_unassigned,
    input  logic [7:0]       cfg_fill_byte,
    input  logic             hec_err_req,
    output logic [CNT_W-1:0] good_cells
);
    localparam int IDX_W = $clog2(CELL_BYTES);

    logic [IDX_W-1:0] idx_q;
    logic             user_q, inj_pend_q, inj_cell_q;
    logic             at_start, at_hec, at_last, in_hdr, in_pay;
    logic             cur_user, ins_hec, fire_hec;
    logic [7:0]       fill_hdr, hdr_byte, pay_raw, pay_scr, crc, hec_byte, nxt_byte;

    // Position decode and source selection for the byte requested now.
    always_comb begin
        at_start = (idx_q == '0);
        at_hec   = (idx_q == IDX_W'(HEC_IDX));
        at_last  = (idx_q == IDX_W'(CELL_BYTES - 1));
        in_hdr   = (idx_q <  IDX_W'(HDR_BYTES));
        in_pay   = (idx_q >  IDX_W'(HEC_IDX));
        cur_user = at_start ? cell_rdy : user_q;
        cell_rd  = out_req && cur_user;
        fill_hdr = (idx_q == IDX_W'(HDR_BYTES - 1)) ? {7'b0, ~cfg_fill_unassigned} : 8'h00;
        hdr_byte = cur_user ? cell_byte : fill_hdr;
        pay_raw  = cur_user ? cell_byte : cfg_fill_byte;
        ins_hec  = !cur_user || cfg_hec_en;
        fire_hec = out_req && at_hec && ins_hec;
        hec_byte = crc ^ cfg_coset ^ {7'b0, inj_pend_q};
    end

    atm_tx_hec u_hec (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (out_req && in_hdr),
        .first (at_start),
        .din   (hdr_byte),
        .crc   (crc)
    );

    atm_tx_scrambler u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (out_req && in_pay && cfg_scr_en),
        .din   (pay_raw),
        .dout  (pay_scr)
    );

    // Choose the outgoing byte for the current position.
    always_comb begin
        if (in_hdr)                  nxt_byte = hdr_byte;
        else if (at_hec)             nxt_byte = ins_hec ? hec_byte : cell_byte;
        else if (cfg_scr_en)         nxt_byte = pay_scr;
        else                         nxt_byte = pay_raw;
    end

    // Byte position within the cell and the source latched at byte 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            user_q <= 1'b0;
        end else if (out_req) begin
            idx_q <= at_last ? '0 : idx_q + IDX_W'(1);
            if (at_start) user_q <= cell_rdy;
        end
    end

    // One-shot check corruption: pending request and whether this cell used it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inj_pend_q <= 1'b0;
            inj_cell_q <= 1'b0;
        end else begin
            if (fire_hec)         inj_pend_q <= hec_err_req;
            else if (hec_err_req) inj_pend_q <= 1'b1;
            if (out_req && at_start) inj_cell_q <= 1'b0;
            else if (fire_hec)       inj_cell_q <= inj_pend_q;
        end
    end

    // Registered output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_soc  <= 1'b0;
            out_byte <= 8'h00;
        end else begin
            out_vld <= out_req;
            out_soc <= out_req && at_start;
            if (out_req) out_byte <= nxt_byte;
        end
    end

    atm_tx_good_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (out_req && at_last && user_q && !inj_cell_q),
        .cnt   (good_cells)
    );

    assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q < IDX_W'(CELL_BYTES));
    assert_soc_has_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> out_vld);
    assert_inj_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_hec && !hec_err_req) |=> !inj_pend_q);
    assert_filler_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !at_start && !user_q) |-> !cell_rd);
endmodule

// File: tb/atm_tx_cell_proc_tb.sv
module atm_tx_cell_proc_tb;
    localparam int CW = 4;

    logic          clk = 0, rst_n = 0;
    logic          cell_rdy = 0, out_req = 0, cfg_hec_en = 1, cfg_scr_en = 0;
    logic          cfg_fill_unassigned = 0, hec_err_req = 0;
    logic [7:0]    cell_byte = 0, cfg_coset = 8'h55, cfg_fill_byte = 8'h6A;
    logic          cell_rd, out_vld, out_soc;
    logic [7:0]    out_byte;
    logic [CW-1:0] good_cells;

    int  errors = 0, checks = 0;
    int  exp_cnt = 0;
    bit  exp_pend = 0;
    bit  hist [0:65535];
    int  hist_n = 0;

    atm_tx_cell_proc #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cell_rdy(cell_rdy), .cell_byte(cell_byte),
        .cell_rd(cell_rd), .out_req(out_req), .out_vld(out_vld), .out_soc(out_soc),
        .out_byte(out_byte), .cfg_hec_en(cfg_hec_en), .cfg_coset(cfg_coset),
        .cfg_scr_en(cfg_scr_en), .cfg_fill_unassigned(cfg_fill_unassigned),
        .cfg_fill_byte(cfg_fill_byte), .hec_err_req(hec_err_req), .good_cells(good_cells)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [31:0] h);
        logic [7:0] c = 8'h00;
        for (int k = 31; k >= 0; k--) begin
            logic fb = c[7] ^ h[k];
            c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

    function automatic logic [7:0] ref_scr(input logic [7:0] r);
        logic [7:0] o;
        for (int k = 7; k >= 0; k--) begin
            bit prev = (hist_n >= 43) ? hist[hist_n - 43] : 1'b0;
            o[k] = r[k] ^ prev;
            hist[hist_n] = o[k];
            hist_n++;
        end
        return o;
    endfunction

    // Sends one cell, compares every byte and the counter. hec_fix<0 means use the model.
    task automatic run_cell(input bit usr, input logic [7:0] seed, input string req,
                            input string what, input int hec_fix);
        logic [7:0] cb [53];
        logic [7:0] eb [53];
        logic [31:0] h;
        bit inj = 0;
        int bad = 0, bad_i = -1, act = 0, ex = 0;
        for (int i = 0; i < 53; i++) cb[i] = (i < 4) ? seed + 8'(i * 29) : seed ^ 8'(i * 7);
        for (int i = 0; i < 4; i++)
            eb[i] = usr ? cb[i] : ((i == 3) ? {7'b0, !cfg_fill_unassigned} : 8'h00);
        h = {eb[0], eb[1], eb[2], eb[3]};
        if (usr && !cfg_hec_en) eb[4] = cb[4];
        else begin
            eb[4] = ref_crc(h) ^ cfg_coset ^ {7'b0, exp_pend};
            inj = exp_pend;
            exp_pend = 0;
        end
        if (hec_fix >= 0) chk(eb[4] == 8'(hec_fix), req, {what, " model hec"}, eb[4], hec_fix);
        for (int i = 5; i < 53; i++) begin
            logic [7:0] r = usr ? cb[i] : cfg_fill_byte;
            eb[i] = cfg_scr_en ? ref_scr(r) : r;
        end
        for (int i = 0; i < 53; i++) begin
            @(negedge clk);
            out_req = 1; cell_rdy = usr; cell_byte = cb[i];
            #1;
            if (cell_rd !== usr && bad == 0) begin bad++; bad_i = i; act = cell_rd; ex = usr; end
            @(negedge clk);
            out_req = 0;
            if ((out_byte !== eb[i] || out_vld !== 1'b1 || out_soc !== (i == 0)) && bad == 0) begin
                bad++; bad_i = i; act = {out_vld, out_soc, out_byte}; ex = {1'b1, i == 0, eb[i]};
            end
        end
        cell_rdy = 0;
        chk(bad == 0, req, $sformatf("%s byte %0d", what, bad_i), act, ex);
        if (usr && !inj && exp_cnt < 15) exp_cnt++;
        chk(good_cells == CW'(exp_cnt), "R8", {what, " good_cells"}, good_cells, exp_cnt);
    endtask

    task automatic t_reset();
        chk(out_vld == 0 && out_soc == 0, "R1", "outputs in reset", {out_vld, out_soc}, 0);
        chk(good_cells == 0, "R1", "count in reset", good_cells, 0);
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cell_rd == 0 && out_vld == 0, "R1", "idle after reset", {cell_rd, out_vld}, 0);
    endtask

    task automatic t_user();
        run_cell(1, 8'h12, "R3", "user cell hec on", -1);
        run_cell(1, 8'hC4, "R2", "second user cell", -1);
        cfg_coset = 8'h3C;
        run_cell(1, 8'h77, "R4", "coset 3C", -1);
        cfg_coset = 8'h55;
        cfg_hec_en = 0;
        run_cell(1, 8'h9B, "R4", "hec insertion off", -1);
        cfg_hec_en = 1;
    endtask

    task automatic t_filler();
        cfg_fill_unassigned = 0;
        run_cell(0, 8'h00, "R6", "idle filler", 8'h52);
        cfg_fill_unassigned = 1; cfg_fill_byte = 8'hA3;
        run_cell(0, 8'h00, "R6", "unassigned filler", 8'h55);
        cfg_fill_unassigned = 0; cfg_fill_byte = 8'h6A;
    endtask

    task automatic t_inject();
        @(negedge clk); hec_err_req = 1; exp_pend = 1;
        @(negedge clk); hec_err_req = 0;
        cfg_hec_en = 0;
        run_cell(1, 8'h31, "R5", "request kept over pass-through", -1);
        cfg_hec_en = 1;
        run_cell(1, 8'h42, "R5", "corrupted cell", -1);
        run_cell(1, 8'h53, "R5", "next cell clean", -1);
        @(negedge clk); hec_err_req = 1; exp_pend = 1;
        @(negedge clk); hec_err_req = 0;
        run_cell(0, 8'h00, "R5", "corrupted filler", 8'h53);
    endtask

    task automatic t_scramble();
        cfg_scr_en = 1;
        run_cell(1, 8'h01, "R7", "scrambled user 1", -1);
        run_cell(0, 8'h00, "R7", "scrambled filler", -1);
        cfg_scr_en = 0;
        run_cell(1, 8'h02, "R7", "scrambler off", -1);
        cfg_scr_en = 1;
        run_cell(1, 8'hF0, "R7", "scrambler resumed", -1);
        cfg_scr_en = 0;
    endtask

    task automatic t_saturate();
        for (int n = 0; n < 12; n++) run_cell(1, 8'(n * 13 + 5), "R8", $sformatf("saturate %0d", n), -1);
        chk(good_cells == CW'(15), "R8", "held at max", good_cells, 15);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_user();
        t_filler();
        t_inject();
        t_scramble();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule